// File: doc/BRIEF.md
# Accumulator Adder and Logic Unit

This block holds a 16-bit working accumulator together with a single extension flag bit, and computes every value that can be written into them. Each clock the caller raises at most one of eleven plain control pins; the unit then writes the chosen result into the accumulator, the extension flag, or both, on the next rising edge.

Nine of the controls write the accumulator:

- bitwise AND with a data operand;
- addition of the data operand, with the carry-out kept in the flag;
- plain transfer of the data operand;
- loading of an 8-bit input character into the low byte only;
- inversion;
- a one-place rotate right or left through the flag;
- clearing;
- increment.

The two remaining controls clear or invert the flag alone.

A single ripple adder serves both addition and increment. One multiplexing cell per bit chooses that bit's next value. Two status outputs are read straight from the stored accumulator: a zero indication and the sign bit. Deciding which control to raise, and moving operands over a bus or to and from memory, belong to the surrounding controller. Every pin is a plain level signal with no handshake. The operands are sampled in the same cycle as the control and need no flow control.

Top module: `accum_logic_unit`

## Requirements
- R1: While `rst_n` is low, the accumulator and the flag are 0. They read 0 after reset is released, until the first control is applied.
- R2: `op_and` writes the bitwise AND of the accumulator and `dr_in` into the accumulator. The flag is unchanged.
- R3: `op_add` writes the low 16 bits of accumulator + `dr_in` into the accumulator, and bit 16 of that sum (the carry-out) into the flag.
- R4: `op_xfer` copies `dr_in` into the accumulator. The flag is unchanged.
- R5: `op_inp` copies `inp_in` into accumulator bits 7:0. Bits 15:8 and the flag are unchanged.
- R6: `op_com` inverts all 16 accumulator bits. The flag is unchanged.
- R7: `op_shr` moves each accumulator bit i+1 to bit i, puts the old flag into bit 15, and puts the old bit 0 into the flag.
- R8: `op_shl` moves each accumulator bit i-1 to bit i, puts the old flag into bit 0, and puts the old bit 15 into the flag.
- R9: `op_clr` writes 0 into the accumulator. The flag is unchanged.
- R10: `op_inc` adds one to the accumulator, wrapping from 16'hFFFF to 16'h0000. The flag is unchanged even on the wrap.
- R11: `op_fclr` writes 0 into the flag and `op_fcom` inverts it. The accumulator is unchanged by either.
- R12: At most one control is high in any cycle; this is the caller's duty. In a cycle with no control high, both the accumulator and the flag keep their values.
- R13: `acc_zero` is 1 exactly when the stored accumulator is 16'h0000. `acc_sign` equals accumulator bit 15. Both follow the stored value in the same cycle, with no extra register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_and | input | 1 | Bitwise AND with data operand |
| op_add | input | 1 | Add data operand, carry to flag |
| op_xfer | input | 1 | Copy data operand |
| op_inp | input | 1 | Load input character into low byte |
| op_com | input | 1 | Invert accumulator |
| op_shr | input | 1 | Rotate right through flag |
| op_shl | input | 1 | Rotate left through flag |
| op_clr | input | 1 | Clear accumulator |
| op_inc | input | 1 | Increment accumulator |
| op_fclr | input | 1 | Clear flag |
| op_fcom | input | 1 | Invert flag |
| dr_in | input | 16 | Data operand |
| inp_in | input | 8 | Input character |
| acc_out | output | 16 | Stored accumulator |
| flag_out | output | 1 | Stored extension flag |
| acc_zero | output | 1 | Accumulator equals zero |
| acc_sign | output | 1 | Accumulator bit 15 |

## Verification
A control and its operands presented in one cycle produce their effect on the accumulator and the flag exactly one rising edge later. The zero and sign outputs change in that same cycle, because they are decoded without a register from the stored value. The bench therefore changes its inputs on the falling edge, advances its behavioural model by one operation, and compares all four outputs at the following falling edge. Each comparison lands one full edge after the stimulus and half a period clear of the next edge.

// File: rtl/accum_pkg.sv
package accum_pkg;
  // Controls that write the accumulator; at most one is high per cycle.
  typedef struct packed {
    logic and_op;
    logic add_op;
    logic xfer_op;
    logic inp_op;
    logic com_op;
    logic shr_op;
    logic shl_op;
    logic clr_op;
    logic inc_op;
  } acc_ctl_t;
endpackage

// File: rtl/accum_op_pack.sv
module accum_op_pack
  import accum_pkg::*;
(
  input  logic     op_and,
  input  logic     op_add,
  input  logic     op_xfer,
  input  logic     op_inp,
  input  logic     op_com,
  input  logic     op_shr,
  input  logic     op_shl,
  input  logic     op_clr,
  input  logic     op_inc,
  output acc_ctl_t ctl
);
  always_comb begin
    ctl.and_op  = op_and;
    ctl.add_op  = op_add;
    ctl.xfer_op = op_xfer;
    ctl.inp_op  = op_inp;
    ctl.com_op  = op_com;
    ctl.shr_op  = op_shr;
    ctl.shl_op  = op_shl;
    ctl.clr_op  = op_clr;
    ctl.inc_op  = op_inc;
  end
endmodule

// File: rtl/accum_ripple_add.sv
module accum_ripple_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] carry;
  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]     = a[i] ^ b[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
  end

  assign cout = carry[W];
endmodule

// File: rtl/accum_bit_cell.sv
module accum_bit_cell
  import accum_pkg::*;
#(
  parameter bit HAS_INP = 1'b1
) (
  input  acc_ctl_t ctl,
  input  logic     acc_bit,
  input  logic     dr_bit,
  input  logic     inp_bit,
  input  logic     sum_bit,
  input  logic     from_left,
  input  logic     from_right,
  output logic     next_bit
);
  always_comb begin
    next_bit = acc_bit;
    if (ctl.and_op)                 next_bit = acc_bit & dr_bit;
    else if (ctl.add_op)            next_bit = sum_bit;
    else if (ctl.inc_op)            next_bit = sum_bit;
    else if (ctl.xfer_op)           next_bit = dr_bit;
    else if (ctl.inp_op && HAS_INP) next_bit = inp_bit;
    else if (ctl.com_op)            next_bit = ~acc_bit;
    else if (ctl.shr_op)            next_bit = from_left;
    else if (ctl.shl_op)            next_bit = from_right;
    else if (ctl.clr_op)            next_bit = 1'b0;
  end
endmodule

// File: rtl/accum_ext_flag.sv
module accum_ext_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic add_op,
  input  logic shr_op,
  input  logic shl_op,
  input  logic inc_op,
  input  logic fclr_op,
  input  logic fcom_op,
  input  logic carry,
  input  logic acc_lsb,
  input  logic acc_msb,
  output logic flag_q
);
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (add_op)       flag_d = carry;
    else if (shr_op)  flag_d = acc_lsb;
    else if (shl_op)  flag_d = acc_msb;
    else if (fclr_op) flag_d = 1'b0;
    else if (fcom_op) flag_d = ~flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  p_inc_keeps_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inc_op |=> $stable(flag_q));
  p_shr_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shr_op |=> flag_q == $past(acc_lsb));
  p_shl_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shl_op |=> flag_q == $past(acc_msb));
  p_fcom_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fcom_op |=> flag_q != $past(flag_q));
  p_fclr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fclr_op |=> !flag_q);
endmodule

// File: rtl/accum_logic_unit.sv
module accum_logic_unit
  import accum_pkg::*;
#(
  parameter int W     = 16,
  parameter int IN_W  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_and,
  input  logic          op_add,
  input  logic          op_xfer,
  input  logic          op_inp,
  input  logic          op_com,
  input  logic          op_shr,
  input  logic          op_shl,
  input  logic          op_clr,
  input  logic          op_inc,
  input  logic          op_fclr,
  input  logic          op_fcom,
  input  logic [W-1:0]  dr_in,
  input  logic [IN_W-1:0] inp_in,
  output logic [W-1:0]  acc_out,
  output logic          flag_out,
  output logic          acc_zero,
  output logic          acc_sign
);
  localparam int MSB = W - 1;

  acc_ctl_t       ctl;
  logic [W-1:0]   acc_q;
  logic [W-1:0]   acc_d;
  logic [W-1:0]   add_b;
  logic [W-1:0]   sum;
  logic           carry;
  logic           flag_q;

  accum_op_pack u_pack (
    .op_and (op_and), .op_add (op_add), .op_xfer (op_xfer), .op_inp (op_inp),
    .op_com (op_com), .op_shr (op_shr), .op_shl (op_shl), .op_clr (op_clr),
    .op_inc (op_inc), .ctl (ctl)
  );

  // One adder: data operand for add, zero plus carry-in for increment.
  assign add_b = ctl.add_op ? dr_in : '0;

  accum_ripple_add #(.W(W)) u_add (
    .a (acc_q), .b (add_b), .cin (ctl.inc_op), .sum (sum), .cout (carry)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic left_v, right_v, inp_v;
    if (i == MSB) begin : g_top
      assign left_v = flag_q;
    end else begin : g_mid_l
      assign left_v = acc_q[i+1];
    end
    if (i == 0) begin : g_bot
      assign right_v = flag_q;
    end else begin : g_mid_r
      assign right_v = acc_q[i-1];
    end
    if (i < IN_W) begin : g_inp
      assign inp_v = inp_in[i];
    end else begin : g_noinp
      assign inp_v = 1'b0;
    end

    accum_bit_cell #(.HAS_INP(i < IN_W)) u_cell (
      .ctl        (ctl),
      .acc_bit    (acc_q[i]),
      .dr_bit     (dr_in[i]),
      .inp_bit    (inp_v),
      .sum_bit    (sum[i]),
      .from_left  (left_v),
      .from_right (right_v),
      .next_bit   (acc_d[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  accum_ext_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .add_op  (ctl.add_op),
    .shr_op  (ctl.shr_op),
    .shl_op  (ctl.shl_op),
    .inc_op  (ctl.inc_op),
    .fclr_op (op_fclr),
    .fcom_op (op_fcom),
    .carry   (carry),
    .acc_lsb (acc_q[0]),
    .acc_msb (acc_q[MSB]),
    .flag_q  (flag_q)
  );

  assign acc_out  = acc_q;
  assign flag_out = flag_q;
  assign acc_zero = (acc_q == '0);
  assign acc_sign = acc_q[MSB];

  logic any_op;
  assign any_op = (|ctl) | op_fclr | op_fcom;

  p_single_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl, op_fclr, op_fcom}));
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !any_op |=> $stable(acc_q) && $stable(flag_q));
  p_and_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_and |=> acc_q == ($past(acc_q) & $past(dr_in)));
  p_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_add |=> {flag_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(dr_in)}));
  p_inp_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_inp |=> acc_q[MSB:IN_W] == $past(acc_q[MSB:IN_W]) && $stable(flag_q));
  p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_clr |=> acc_q == '0);
  p_flag_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fclr || op_fcom) |=> $stable(acc_q));
endmodule

// File: tb/accum_logic_unit_tb.sv
module accum_logic_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_and = 0, op_add = 0, op_xfer = 0, op_inp = 0, op_com = 0;
  logic        op_shr = 0, op_shl = 0, op_clr = 0, op_inc = 0, op_fclr = 0, op_fcom = 0;
  logic [15:0] dr_in = '0;
  logic [7:0]  inp_in = '0;
  logic [15:0] acc_out;
  logic        flag_out, acc_zero, acc_sign;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_acc = '0;
  logic        m_flag = 1'b0;

  always #4 clk = ~clk;

  accum_logic_unit u_dut (
    .clk (clk), .rst_n (rst_n),
    .op_and (op_and), .op_add (op_add), .op_xfer (op_xfer), .op_inp (op_inp),
    .op_com (op_com), .op_shr (op_shr), .op_shl (op_shl), .op_clr (op_clr),
    .op_inc (op_inc), .op_fclr (op_fclr), .op_fcom (op_fcom),
    .dr_in (dr_in), .inp_in (inp_in),
    .acc_out (acc_out), .flag_out (flag_out), .acc_zero (acc_zero), .acc_sign (acc_sign)
  );

  // Operation codes used by the bench only: 0 and,1 add,2 xfer,3 inp,4 com,
  // 5 shr,6 shl,7 clr,8 inc,9 fclr,10 fcom,11 none.
  function automatic string tag_of(int code);
    case (code)
      0: return "R2";  1: return "R3";  2: return "R4";  3: return "R5";
      4: return "R6";  5: return "R7";  6: return "R8";  7: return "R9";
      8: return "R10"; 9: return "R11"; 10: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic drive(int code);
    op_and = (code == 0); op_add = (code == 1); op_xfer = (code == 2);
    op_inp = (code == 3); op_com = (code == 4); op_shr = (code == 5);
    op_shl = (code == 6); op_clr = (code == 7); op_inc = (code == 8);
    op_fclr = (code == 9); op_fcom = (code == 10);
  endtask

  task automatic model(int code, logic [15:0] d, logic [7:0] ip);
    logic [16:0] s;
    logic        f;
    case (code)
      0: m_acc = m_acc & d;
      1: begin s = {1'b0, m_acc} + {1'b0, d}; m_acc = s[15:0]; m_flag = s[16]; end
      2: m_acc = d;
      3: m_acc[7:0] = ip;
      4: m_acc = ~m_acc;
      5: begin f = m_acc[0]; m_acc = {m_flag, m_acc[15:1]}; m_flag = f; end
      6: begin f = m_acc[15]; m_acc = {m_acc[14:0], m_flag}; m_flag = f; end
      7: m_acc = 16'h0000;
      8: m_acc = m_acc + 16'h0001;
      9: m_flag = 1'b0;
      10: m_flag = ~m_flag;
      default: ;
    endcase
  endtask

  task automatic compare(string tag);
    checks++;
    if (acc_out !== m_acc || flag_out !== m_flag) begin
      errors++;
      $display("FAIL %s acc=%h flag=%b expected acc=%h flag=%b", tag, acc_out, flag_out, m_acc, m_flag);
    end
    checks++;
    if (acc_zero !== (m_acc == 16'h0000) || acc_sign !== m_acc[15]) begin
      errors++;
      $display("FAIL R13 zero=%b sign=%b expected zero=%b sign=%b",
               acc_zero, acc_sign, (m_acc == 16'h0000), m_acc[15]);
    end
  endtask

  // Called at a falling edge: apply, let one rising edge pass, compare.
  task automatic step(int code, logic [15:0] d, logic [7:0] ip);
    drive(code);
    dr_in = d;
    inp_in = ip;
    model(code, d, ip);
    @(negedge clk);
    compare(tag_of(code));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");          // reset state held while in reset
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");          // still zero after release with no control

    step(2, 16'h1234, 8'h00);   // R4 transfer
    step(0, 16'h0FF0, 8'h00);   // R2 and -> 0230
    step(1, 16'hFFFF, 8'h00);   // R3 add with carry -> 022F, flag 1
    step(1, 16'h0001, 8'h00);   // R3 add without carry -> flag 0
    step(3, 16'hAAAA, 8'h5C);   // R5 low byte only
    step(4, 16'h0000, 8'h00);   // R6 invert
    step(10, 16'h0000, 8'h00);  // R11 flag invert -> 1
    step(5, 16'h0000, 8'h00);   // R7 flag enters bit 15
    step(6, 16'h0000, 8'h00);   // R8 bit 15 leaves to flag
    step(11, 16'hFFFF, 8'hFF);  // R12 hold with busy operands
    step(9, 16'h0000, 8'h00);   // R11 flag clear
    step(2, 16'hFFFF, 8'h00);
    step(10, 16'h0000, 8'h00);  // flag = 1
    step(8, 16'h0000, 8'h00);   // R10 wrap to 0000, flag stays 1
    step(7, 16'h0000, 8'h00);   // R9 clear
    step(2, 16'h8000, 8'h00);   // R13 sign set
    step(5, 16'h0000, 8'h00);   // R7 rotate right from 8000

    for (int k = 0; k < 2000; k++) begin
      step(int'($urandom_range(0, 11)), 16'($urandom), 8'($urandom));
    end

    drive(11);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule